// File: doc/BRIEF.md
# Dual 24-bit Time Base

This block holds two free-running 24-bit counters that channel logic uses as common time references. Counter A advances either on the system clock, divided by an even ratio from 2 to 512, or on rising edges of an external clock, divided by a ratio from 1 to 256. Counter B advances on an external clock or on the system clock divided by eight. Either source then passes through its own prescaler with a ratio from 1 to 256. Counter B can also run as a pulse accumulator: a prescaled tick adds one only while an external gate input is high.

The engine side reads both counters directly and may load either one at any time. A load also restarts the prescaler phase of that counter. The host side sees one counter at a time through a select input. It has a write strobe that the block ignores, so host software can never change a time reference.

Top module: `dual_timebase`

## Requirements
- R1: After reset both counters read zero on `cnt_a`, `cnt_b` and `host_rdata`.
- R2: With `a_src_ext`=0, counter A advances once every 2*(`a_div`+1) system clocks, counted from the load that last cleared its prescaler.
- R3: With `a_src_ext`=1, counter A advances once every (`a_div`+1) rising edges of `ext_clk_a`. The input passes through a two-flop synchronizer and an edge detector first.
- R4: With `b_src_ext`=0, counter B advances once every 8*(`b_div`+1) system clocks, counted from the last load of B. A load of B also restarts the divide-by-8 stage.
- R5: With `b_src_ext`=1, counter B advances once every (`b_div`+1) synchronized rising edges of `ext_clk_b`.
- R6: With `b_accum`=1, a prescaled tick of counter B adds one only while `b_gate` is high. While `b_gate` is low, counter B holds its value.
- R7: A pulse on `eng_wr_a` or `eng_wr_b` loads `eng_wdata` into that counter at the next clock edge. The load overrides any increment in that cycle and resets that counter's prescaler phase to zero.
- R8: A counter wraps from 0xFFFFFF to 0x000000 with no flag or other side effect.
- R9: `host_rdata` shows counter A when `host_sel`=0 and counter B when `host_sel`=1.
- R10: `host_wr` and `host_wdata` have no effect on either counter.
- R11: Without a load, a counter changes by at most +1 from one clock to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_src_ext | input | 1 | Counter A source: 0 system clock, 1 external clock |
| a_div | input | 8 | Counter A prescaler field |
| b_src_ext | input | 1 | Counter B source: 0 system clock / 8, 1 external clock |
| b_div | input | 8 | Counter B prescaler field, ratio field+1 |
| b_accum | input | 1 | Counter B gated pulse-accumulate mode |
| b_gate | input | 1 | Accumulate gate, synchronous to clk |
| ext_clk_a | input | 1 | Asynchronous external clock for counter A |
| ext_clk_b | input | 1 | Asynchronous external clock for counter B |
| eng_wr_a | input | 1 | Engine load strobe for counter A |
| eng_wr_b | input | 1 | Engine load strobe for counter B |
| eng_wdata | input | 24 | Engine load value |
| cnt_a | output | 24 | Engine view of counter A |
| cnt_b | output | 24 | Engine view of counter B |
| host_sel | input | 1 | Host read select: 0 A, 1 B |
| host_wr | input | 1 | Host write strobe (ignored) |
| host_wdata | input | 24 | Host write data (ignored) |
| host_rdata | output | 24 | Host read data |

## Verification
The hardest states to reach from the ports are the prescaler end points. These are the 512-clock ratio on counter A and the moment a counter passes 0xFFFFFF. Waiting for them from reset would take millions of cycles. The stimulus first loads a value just below the wrap point, which also zeroes the prescaler phase. After that load, the exact number of increments in a chosen number of clocks is known, so each table row can run the widest ratio within about a thousand cycles. The external and gated paths are driven with whole pulses and whole gate windows that end well clear of the synchronizer delay, so the expected count does not depend on which clock the synchronizer catches an edge in.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int TB_CNT_W = 24;
  localparam int TB_DIV_W = 8;
  localparam int TB_PH_W  = TB_DIV_W + 1;

  // Terminal phase of counter A: ratio 2*(f+1) on system clock, f+1 on external edges
  function automatic logic [TB_PH_W-1:0] a_terminal(input logic ext, input logic [TB_DIV_W-1:0] f);
    if (ext) a_terminal = {1'b0, f};
    else     a_terminal = {f, 1'b1};
  endfunction

  // Terminal phase of counter B: ratio f+1 on either source
  function automatic logic [TB_PH_W-1:0] b_terminal(input logic [TB_DIV_W-1:0] f);
    b_terminal = {1'b0, f};
  endfunction
endpackage

// File: rtl/tbase_sync_edge.sv
module tbase_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_in};
  end

  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int PH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [PH_W-1:0] terminal,
  output logic            tick
);
  logic [PH_W-1:0] phase;

  assign tick = en && (phase >= terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (clr)  phase <= '0;
    else if (tick) phase <= '0;
    else if (en)   phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end
endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import tbase_pkg::*;
#(
  parameter int CNT_W = TB_CNT_W,
  parameter int DIV_W = TB_DIV_W,
  parameter int SYS_B_DIV_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_src_ext,
  input  logic [DIV_W-1:0] a_div,
  input  logic             b_src_ext,
  input  logic [DIV_W-1:0] b_div,
  input  logic             b_accum,
  input  logic             b_gate,
  input  logic             ext_clk_a,
  input  logic             ext_clk_b,
  input  logic             eng_wr_a,
  input  logic             eng_wr_b,
  input  logic [CNT_W-1:0] eng_wdata,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rdata
);
  localparam int PH_W = DIV_W + 1;

  logic [1:0] ext_in;
  logic [1:0] ext_rise;
  assign ext_in = {ext_clk_b, ext_clk_a};

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_sync
      tbase_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in[gi]),
        .rise     (ext_rise[gi])
      );
    end
  endgenerate

  // Fixed system-clock divider feeding counter B, restarted by a load of B
  logic [SYS_B_DIV_LOG2-1:0] sysdiv_q;
  logic                      sysdiv_pulse;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sysdiv_q <= '0;
    else if (eng_wr_b) sysdiv_q <= '0;
    else               sysdiv_q <= sysdiv_q + 1'b1;
  end
  assign sysdiv_pulse = &sysdiv_q;

  // Named internal events
  logic            en_a, en_b, tick_a, tick_b, inc_a, inc_b;
  logic [PH_W-1:0] term_a, term_b;

  assign en_a   = a_src_ext ? ext_rise[0] : 1'b1;
  assign en_b   = b_src_ext ? ext_rise[1] : sysdiv_pulse;
  assign term_a = a_terminal(a_src_ext, a_div);
  assign term_b = b_terminal(b_div);

  tbase_prescaler #(.PH_W(PH_W)) u_pre_a (
    .clk(clk), .rst_n(rst_n), .clr(eng_wr_a), .en(en_a), .terminal(term_a), .tick(tick_a)
  );
  tbase_prescaler #(.PH_W(PH_W)) u_pre_b (
    .clk(clk), .rst_n(rst_n), .clr(eng_wr_b), .en(en_b), .terminal(term_b), .tick(tick_b)
  );

  assign inc_a = tick_a;
  assign inc_b = tick_b && (!b_accum || b_gate);

  tbase_counter #(.W(CNT_W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .load(eng_wr_a), .load_val(eng_wdata), .inc(inc_a), .q(cnt_a)
  );
  tbase_counter #(.W(CNT_W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .load(eng_wr_b), .load_val(eng_wdata), .inc(inc_b), .q(cnt_b)
  );

  // Host side is read-only; its write strobe and data reach no state
  logic host_unused;
  assign host_unused = host_wr ^ (^host_wdata);

  assign host_rdata = host_sel ? cnt_b : cnt_a;
endmodule

// File: rtl/tbase_checker.sv
module tbase_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_wr_a,
  input logic             eng_wr_b,
  input logic [CNT_W-1:0] eng_wdata,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic             b_accum,
  input logic             b_gate,
  input logic             a_src_ext,
  input logic             tick_a
);
  // R7: loads land on the next edge
  a_r7_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr_a |=> cnt_a == $past(eng_wdata));
  a_r7_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr_b |=> cnt_b == $past(eng_wdata));

  // R11 and R8: one step at most, wrapping silently
  a_r11_step_a: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_wr_a |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 24'd1));
  a_r11_step_b: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_wr_b |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + 24'd1));

  // R6: closed gate holds counter B
  a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_accum && !b_gate && !eng_wr_b) |=> $stable(cnt_b));

  // R2: on the system clock the ratio is at least two
  a_r2_even_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && !a_src_ext && !eng_wr_a) |=> (!tick_a || a_src_ext));
endmodule

bind dual_timebase tbase_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_wr_a(eng_wr_a), .eng_wr_b(eng_wr_b),
  .eng_wdata(eng_wdata), .cnt_a(cnt_a), .cnt_b(cnt_b), .b_accum(b_accum),
  .b_gate(b_gate), .a_src_ext(a_src_ext), .tick_a(tick_a)
);

// File: tb/sim_dual_timebase.sv
module sim_dual_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_src_ext = 1'b0, b_src_ext = 1'b1, b_accum = 1'b0, b_gate = 1'b0;
  logic [7:0]  a_div = '0, b_div = '0;
  logic        ext_clk_a = 1'b0, ext_clk_b = 1'b0;
  logic        eng_wr_a = 1'b0, eng_wr_b = 1'b0;
  logic [23:0] eng_wdata = '0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [23:0] host_wdata = '0;
  logic [23:0] cnt_a, cnt_b, host_rdata;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_timebase u0 (
    .clk(clk), .rst_n(rst_n), .a_src_ext(a_src_ext), .a_div(a_div),
    .b_src_ext(b_src_ext), .b_div(b_div), .b_accum(b_accum), .b_gate(b_gate),
    .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b), .eng_wr_a(eng_wr_a),
    .eng_wr_b(eng_wr_b), .eng_wdata(eng_wdata), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .host_sel(host_sel), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  typedef struct packed {
    logic [7:0]  fld;
    logic [23:0] start;
    logic [15:0] ncyc;
  } vec_t;

  // Counter A on the system clock: ratio 2*(fld+1)
  localparam vec_t VEC [5] = '{
    '{8'd0,   24'h000100, 16'd10},
    '{8'd3,   24'h000200, 16'd20},
    '{8'd1,   24'h000300, 16'd3},
    '{8'd255, 24'h000400, 16'd1100},
    '{8'd0,   24'hFFFFFE, 16'd6}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_a(input logic [23:0] v);
    @(negedge clk); eng_wr_a = 1'b1; eng_wdata = v;
    @(negedge clk); eng_wr_a = 1'b0;
  endtask

  task automatic load_b(input logic [23:0] v);
    @(negedge clk); eng_wr_b = 1'b1; eng_wdata = v;
    @(negedge clk); eng_wr_b = 1'b0;
  endtask

  task automatic pulses(input bit sel_b, input int n);
    for (int k = 0; k < n; k++) begin
      if (sel_b) ext_clk_b = 1'b1; else ext_clk_a = 1'b1;
      repeat (2) @(negedge clk);
      if (sel_b) ext_clk_b = 1'b0; else ext_clk_a = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cnt_a reset", cnt_a, 24'h0);
    check("R1 cnt_b reset", cnt_b, 24'h0);
    check("R1 host_rdata reset", host_rdata, 24'h0);
    rst_n = 1'b1;

    // Table: counter A on the system clock, each row begins with a load (R2, R7, R8)
    for (int i = 0; i < 5; i++) begin
      int ratio;
      a_div = VEC[i].fld;
      load_a(VEC[i].start);
      repeat (int'(VEC[i].ncyc)) @(negedge clk);
      ratio = 2 * (int'(VEC[i].fld) + 1);
      check($sformatf("R2/R7/R8 row %0d", i), cnt_a,
            VEC[i].start + 24'(int'(VEC[i].ncyc) / ratio));
    end

    // R7: load value appears right after the load edge
    load_a(24'hABCDEF);
    check("R7 load visible", cnt_a, 24'hABCDEF);

    // R3: external source, ratio 3 and ratio 1
    a_src_ext = 1'b1; a_div = 8'd2;
    load_a(24'h000010);
    pulses(1'b0, 7);
    check("R3 ext ratio 3", cnt_a, 24'h000012);
    a_div = 8'd0;
    load_a(24'h000020);
    pulses(1'b0, 4);
    check("R3 ext ratio 1", cnt_a, 24'h000024);

    // R5: counter B external, ratio 2
    b_src_ext = 1'b1; b_div = 8'd1;
    load_b(24'h000000);
    pulses(1'b1, 5);
    check("R5 ext ratio 2", cnt_b, 24'h000002);

    // R9 and R10: both counters idle on external sources with no edges
    load_b(24'h123456);
    load_a(24'h654321);
    @(negedge clk); host_wr = 1'b1; host_wdata = 24'hFFFFFF; host_sel = 1'b1;
    @(negedge clk); host_sel = 1'b0;
    @(negedge clk); host_wr = 1'b0;
    check("R10 host write B ignored", cnt_b, 24'h123456);
    check("R10 host write A ignored", cnt_a, 24'h654321);
    check("R9 host reads A", host_rdata, 24'h654321);
    host_sel = 1'b1; #1;
    check("R9 host reads B", host_rdata, 24'h123456);

    // R4: system clock / 8 with ratio 2 -> one step per 16 clocks
    b_src_ext = 1'b0; b_div = 8'd1;
    load_b(24'h000100);
    repeat (40) @(negedge clk);
    check("R4 sysclk/8 ratio 2", cnt_b, 24'h000102);

    // R6: accumulate with gate closed, then open for 20 clocks
    b_div = 8'd0; b_accum = 1'b1; b_gate = 1'b0;
    load_b(24'h000050);
    repeat (40) @(negedge clk);
    check("R6 gate closed", cnt_b, 24'h000050);
    @(negedge clk); eng_wr_b = 1'b1; eng_wdata = 24'h000060; b_gate = 1'b1;
    @(negedge clk); eng_wr_b = 1'b0;
    repeat (19) @(negedge clk);
    b_gate = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 gated window", cnt_b, 24'h000062);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule